// File: doc/BRIEF.md
# PWM Generator with Synchronized Triggers

This block drives one pulse width modulated line from a free-running tick counter. Period, on-time and control-trigger lead are all counted in clock ticks and may be changed while the block runs. Alongside the PWM line it produces three strobes that share the PWM cycle's timebase. A sample trigger rises in the middle of the on-time, where the current in an inductive load equals its average. A control trigger rises a chosen number of ticks before the cycle ends, which leaves a fixed window for a control loop to compute the next duty. A start flag marks the first tick of every cycle.

New settings take effect only at the next cycle boundary, so every cycle runs on one consistent set of values. Out-of-range settings are clamped. This keeps each strobe at one rising edge per cycle, whatever the input values.

Top module: `pwm_trig_gen`

## Requirements
- R1: While `rst` is high on a rising clock edge, all four outputs are low from that edge on and the cycle count returns to zero.
- R2: While `en` is low, all four outputs are low from the next edge. The first edge that samples `en` high (with `rst` low) starts a new cycle, so `start_o` is high in the following tick.
- R3: A cycle lasts P = max(`period_i`, 3) ticks, numbered 0 to P-1. `start_o` is high in tick 0 and low in every other tick.
- R4: `period_i`, `duty_i` and `lead_i` are sampled only on the edge that begins a cycle. A change during a cycle has no effect until the next cycle.
- R5: With D = min(`duty_i`, P), `pwm_o` is high in ticks 0 to D-1 and low for the rest of the cycle. D = 0 keeps it low for the whole cycle, and D = P keeps it high for the whole cycle.
- R6: `smp_o` rises in tick floor(D/2). It stays high while the tick number is below floor(D/2)+floor(P/2), but is always low in tick P-1. With D = 0 it stays low for the whole cycle.
- R7: With L equal to `lead_i`, clamped to the range 1 to P-1 (0 becomes 1), `ctl_o` rises in tick P-L. It stays high for min(floor(P/2), L) ticks.
- R8: `ctl_o` is low in tick 0 of every cycle, and each rise of `smp_o` happens while `pwm_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low stops the cycle and clears outputs |
| period_i | input | CNT_W | Cycle length in ticks |
| duty_i | input | CNT_W | On-time in ticks |
| lead_i | input | CNT_W | Ticks from the control-trigger rise to the cycle end |
| pwm_o | output | 1 | PWM line |
| smp_o | output | 1 | Mid-on-time sample trigger |
| ctl_o | output | 1 | Control-loop trigger |
| start_o | output | 1 | One-tick cycle-start flag |

## Verification
On every cycle the assertions check several ordering properties. The start flag never lasts two ticks. The PWM line rises only at a cycle start. The control trigger is low at a cycle start. The sample trigger rises only inside the on-time. Outputs stay low while the block is disabled. The exact tick positions of the edges, the clamping of period, duty and lead, and the rule that settings are held until a boundary depend on the values applied. Only the bench's reference model can show those, across its directed corners and randomized mid-run setting changes.

// File: rtl/pwm_trig_pkg.sv
package pwm_trig_pkg;
   // Shortest cycle that leaves room for a sample rise before the last tick
   localparam int MIN_PERIOD = 3;

   typedef struct packed {
      logic pwm;
      logic smp;
      logic ctl;
      logic stp;
   } pwm_flags_t;
endpackage

// File: rtl/pwm_trig_cnt.sv
module pwm_trig_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic [CNT_W-1:0] lead_i,
   output logic             run_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] per_q,
   output logic [CNT_W-1:0] dty_q,
   output logic [CNT_W-1:0] ld_q
);
   localparam logic [CNT_W-1:0] P_MIN = CNT_W'(pwm_trig_pkg::MIN_PERIOD);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   logic [CNT_W-1:0] per_c, dty_c, ld_c;
   logic             wrap;

   // clamp the incoming settings so every strobe keeps one edge per cycle
   always_comb begin
      per_c = (period_i < P_MIN) ? P_MIN : period_i;
      dty_c = (duty_i > per_c) ? per_c : duty_i;
      if (lead_i == '0)
         ld_c = ONE;
      else if (lead_i > per_c - ONE)
         ld_c = per_c - ONE;
      else
         ld_c = lead_i;
   end

   assign wrap = (cnt_q == per_q - ONE);

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (!run_q || wrap) begin
         run_q <= 1'b1;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end

   // settings change only on the edge that opens a cycle
   always_ff @(posedge clk) begin
      if (rst) begin
         per_q <= P_MIN;
         dty_q <= '0;
         ld_q  <= ONE;
      end else if (en && (!run_q || wrap)) begin
         per_q <= per_c;
         dty_q <= dty_c;
         ld_q  <= ld_c;
      end
   end
endmodule

// File: rtl/pwm_trig_win.sv
module pwm_trig_win #(
   parameter int CNT_W = 16
) (
   input  logic             gate,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] lo,
   input  logic [CNT_W-1:0] len,
   output logic             hit
);
   logic [CNT_W:0] hi;

   assign hi  = {1'b0, lo} + {1'b0, len};
   assign hit = gate && (cnt >= lo) && ({1'b0, cnt} < hi);
endmodule

// File: rtl/pwm_trig_gen.sv
module pwm_trig_gen #(
   parameter int CNT_W   = 16,
   parameter int REG_OUT = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic [CNT_W-1:0] lead_i,
   output logic             pwm_o,
   output logic             smp_o,
   output logic             ctl_o,
   output logic             start_o
);
   import pwm_trig_pkg::*;

   if (CNT_W < 3) begin : g_bad_width
      $error("pwm_trig_gen: CNT_W must be at least 3");
   end
   if (REG_OUT < 0 || REG_OUT > 1) begin : g_bad_regout
      $error("pwm_trig_gen: REG_OUT must be 0 or 1");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             run_q;
   logic [CNT_W-1:0] cnt_q, per_q, dty_q, ld_q;
   logic [CNT_W-1:0] half, mid, ctl_pt;
   logic             smp_gate;
   pwm_flags_t       nxt;

   pwm_trig_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .period_i (period_i),
      .duty_i   (duty_i),
      .lead_i   (lead_i),
      .run_q    (run_q),
      .cnt_q    (cnt_q),
      .per_q    (per_q),
      .dty_q    (dty_q),
      .ld_q     (ld_q)
   );

   assign half     = per_q >> 1;
   assign mid      = dty_q >> 1;
   assign ctl_pt   = per_q - ld_q;
   assign smp_gate = run_q && (dty_q != '0) && (cnt_q != per_q - ONE);

   pwm_trig_win #(.CNT_W(CNT_W)) u_smp_win (
      .gate (smp_gate),
      .cnt  (cnt_q),
      .lo   (mid),
      .len  (half),
      .hit  (nxt.smp)
   );

   pwm_trig_win #(.CNT_W(CNT_W)) u_ctl_win (
      .gate (run_q),
      .cnt  (cnt_q),
      .lo   (ctl_pt),
      .len  (half),
      .hit  (nxt.ctl)
   );

   assign nxt.pwm = run_q && (cnt_q < dty_q);
   assign nxt.stp = run_q && (cnt_q == '0);

   if (REG_OUT == 1) begin : g_reg_out
      pwm_flags_t out_q;
      always_ff @(posedge clk) begin
         if (rst) out_q <= '0;
         else     out_q <= nxt;
      end
      assign {pwm_o, smp_o, ctl_o, start_o} = out_q;
   end else begin : g_comb_out
      assign {pwm_o, smp_o, ctl_o, start_o} = nxt;
   end
endmodule

// File: rtl/pwm_trig_sva.sv
module pwm_trig_sva #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic [CNT_W-1:0] period_i,
   input logic             pwm_o,
   input logic             smp_o,
   input logic             ctl_o,
   input logic             start_o
);
   AST_START_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
      start_o |=> !start_o); // R3

   AST_PWM_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_o) |-> start_o); // R5

   AST_CTL_LOW_AT_START: assert property (@(posedge clk) disable iff (rst)
      start_o |-> !ctl_o); // R8

   AST_SMP_INSIDE_ON: assert property (@(posedge clk) disable iff (rst)
      $rose(smp_o) |-> pwm_o); // R8

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
      (!en && $past(!en)) |=> !(pwm_o || smp_o || ctl_o || start_o)); // R2
endmodule

bind pwm_trig_gen pwm_trig_sva #(.CNT_W(CNT_W)) u_sva (
   .clk      (clk),
   .rst      (rst),
   .en       (en),
   .period_i (period_i),
   .pwm_o    (pwm_o),
   .smp_o    (smp_o),
   .ctl_o    (ctl_o),
   .start_o  (start_o)
);

// File: tb/sim_pwm_trig_gen.sv
module sim_pwm_trig_gen;
   localparam int W = 16;

   logic clk = 1'b0, rst = 1'b1, en = 1'b0;
   logic [W-1:0] period = '0, duty = '0, lead = '0;
   logic pwm, smp, ctl, stp;

   always #10 clk = ~clk;

   pwm_trig_gen #(.CNT_W(W)) u0 (
      .clk(clk), .rst(rst), .en(en), .period_i(period), .duty_i(duty),
      .lead_i(lead), .pwm_o(pwm), .smp_o(smp), .ctl_o(ctl), .start_o(stp));

   int total = 0, bad = 0;
   bit cmp_on = 0, done = 0;

   function automatic int clamp_p(int p); return (p < 3) ? 3 : p; endfunction
   function automatic int clamp_d(int d, int p); return (d > p) ? p : d; endfunction
   function automatic int clamp_l(int l, int p);
      if (l == 0) return 1;
      if (l > p - 1) return p - 1;
      return l;
   endfunction

   // reference model of the requirements
   bit m_run = 0;
   int m_cnt = 0, m_p = 3, m_d = 0, m_l = 1;
   always @(posedge clk) begin
      if (rst || !en) begin
         m_run <= 0; m_cnt <= 0;
      end else if (!m_run || m_cnt == m_p - 1) begin
         m_run <= 1; m_cnt <= 0;
         m_p <= clamp_p(int'(period));
         m_d <= clamp_d(int'(duty), clamp_p(int'(period)));
         m_l <= clamp_l(int'(lead), clamp_p(int'(period)));
      end else begin
         m_cnt <= m_cnt + 1;
      end
   end

   task automatic chk(string tag, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (cmp_on) begin
      int half, mid, pt;
      half = m_p / 2; mid = m_d / 2; pt = m_p - m_l;
      chk("R3 start", stp, m_run && m_cnt == 0);
      chk("R5 pwm", pwm, m_run && m_cnt < m_d);
      chk("R6 smp", smp, m_run && m_d > 0 && m_cnt >= mid && m_cnt < mid + half
                          && m_cnt != m_p - 1);
      chk("R7 ctl", ctl, m_run && m_cnt >= pt && m_cnt < pt + half);
      if (stp) chk("R8 ctl at start", ctl, 1'b0);
   end

   task automatic set(int p, int d, int l);
      period = W'(p); duty = W'(d); lead = W'(l);
   endtask

   task automatic wait_start();
      do @(negedge clk); while (!stp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int cnt_hi;
      void'($urandom(32'h5eed));
      repeat (4) @(negedge clk);
      chk("R1 pwm", pwm, 0); chk("R1 smp", smp, 0);
      chk("R1 ctl", ctl, 0); chk("R1 start", stp, 0);
      set(10, 4, 3); en = 1; rst = 0; cmp_on = 1;
      @(negedge clk);
      chk("R2 first start", stp, 1'b1);

      // R4: mid-cycle duty change waits for the boundary
      wait_start();
      cnt_hi = 0;
      for (int i = 0; i < 10; i++) begin
         if (i == 2) duty = W'(8);
         if (pwm) cnt_hi++;
         @(negedge clk);
      end
      total++;
      if (cnt_hi != 4) begin bad++; $display("FAIL R4 act=%0d exp=4", cnt_hi); end
      cnt_hi = 0;
      for (int i = 0; i < 10; i++) begin
         if (pwm) cnt_hi++;
         @(negedge clk);
      end
      total++;
      if (cnt_hi != 8) begin bad++; $display("FAIL R4 act=%0d exp=8", cnt_hi); end

      // corners: clamped period/lead, zero duty, full duty, oversize lead
      set(0, 0, 0);   repeat (20) @(negedge clk);
      set(2, 1, 1);   repeat (20) @(negedge clk);
      set(7, 100, 100); repeat (30) @(negedge clk);
      set(8, 8, 1);   repeat (30) @(negedge clk);
      set(9, 1, 8);   repeat (30) @(negedge clk);

      // R2: disable clears outputs, re-enable restarts at once
      en = 0; @(negedge clk);
      chk("R2 off pwm", pwm, 0); chk("R2 off start", stp, 0);
      en = 1; @(negedge clk);
      chk("R2 restart", stp, 1'b1);

      // R1: reset mid-run
      repeat (3) @(negedge clk);
      rst = 1; @(negedge clk);
      chk("R1 mid pwm", pwm, 0); chk("R1 mid ctl", ctl, 0);
      rst = 0;

      // random phase with mid-cycle setting changes
      for (int s = 0; s < 300; s++) begin
         set($urandom_range(0, 40), $urandom_range(0, 45), $urandom_range(0, 45));
         if ($urandom_range(0, 9) == 0) begin en = 0; @(negedge clk); en = 1; end
         repeat ($urandom_range(1, 60)) @(negedge clk);
      end

      cmp_on = 0; done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule